// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces a single successive-approximation converter that is shared between general analog inputs and the measurement phases of a resistive touch panel. A trigger starts a sequence. If the converter is powered down, the sequencer first holds off for a programmable wake-up interval. It then visits every enabled channel in ascending index order. For each channel it runs a sample-and-hold window and issues a one-cycle convert strobe. It then waits until the converter reports completion before moving on.

Each channel carries a type bit that selects which of two sample-hold lengths applies: one for plain analog inputs and one for touch inputs. For a touch input, the panel power switches are closed for exactly the touch sample-hold window and open again before the strobe. The channel mask, the type bits and both sample-hold lengths are captured when a trigger is accepted. When a sequence ends, a sleep-mode input decides whether the converter is powered down again, so that the next trigger pays the wake-up cost again, or whether it stays powered. The block has no streaming data path. All its pins are plain control and status levels or pulses, and the convert handshake is a strobe followed by a completion pulse rather than a valid/ready pair.

Top module: `adc_seq_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every output is low, and `adc_pwr_o` low means the converter is powered down.
- R2: A trigger accepted while powered down with at least one channel enabled asserts `waking_o` from the next cycle, for exactly (N+1)*8 consecutive cycles, where N is the 7-bit `startup_cfg_i`. The first sample cycle follows immediately after.
- R3: A trigger accepted while powered up starts sampling of the first enabled channel in the very next cycle, with no wake-up cycles.
- R4: Channels are converted from the lowest enabled index to the highest, one conversion per set bit of `ch_en_i`, and disabled channels cost no cycles. Sampling of the next channel begins in the cycle right after the cycle in which `conv_done_i` is accepted.
- R5: The sample-hold window lasts M+1 cycles, with `sample_o` high. M is the 4-bit `sh_ts_cfg_i` when the channel's bit in `ch_is_ts_i` is 1 (touch input), and the 4-bit `sh_ana_cfg_i` when that bit is 0 (analog input).
- R6: `ts_sw_en_o` is high in every sample cycle of a touch channel and in no other cycle: never while an analog channel samples, and never in the strobe cycle.
- R7: `conv_start_o` is a single-cycle pulse in the cycle right after the last sample cycle. `ch_sel_o` stays constant from the first sample cycle through the strobe.
- R8: After a strobe the block does no further sampling until `conv_done_i` is seen. The done input is only accepted in cycles after the strobe cycle.
- R9: `seq_done_o` pulses for one cycle right after the done of the last channel is accepted. In the following cycle `busy_o` is low, and `adc_pwr_o` is low if `sleep_mode_i` was high during the pulse and high otherwise.
- R10: A trigger that arrives while `busy_o` is high has no effect. The enable mask, the type bits and the sample-hold settings are captured when a trigger is accepted, so later changes to them do not affect the running sequence.
- R11: A trigger accepted with an all-zero enable mask produces `seq_done_o` in the next cycle, with no wake-up, sampling or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Sequence start request |
| sleep_mode_i | input | 1 | Power down the converter after each sequence |
| startup_cfg_i | input | 7 | Wake-up length N, giving (N+1)*8 cycles |
| sh_ana_cfg_i | input | 4 | Analog sample-hold length M, giving M+1 cycles |
| sh_ts_cfg_i | input | 4 | Touch sample-hold length M, giving M+1 cycles |
| ch_en_i | input | 8 | Channel enable mask |
| ch_is_ts_i | input | 8 | Per-channel type, 1 = touch input |
| conv_done_i | input | 1 | Converter finished the current conversion |
| adc_pwr_o | output | 1 | Converter powered |
| busy_o | output | 1 | Sequence in progress |
| waking_o | output | 1 | Wake-up interval running |
| sample_o | output | 1 | Sample-hold window active |
| ts_sw_en_o | output | 1 | Touch panel power switches closed |
| conv_start_o | output | 1 | Convert strobe |
| ch_sel_o | output | 3 | Selected channel index |
| seq_done_o | output | 1 | Sequence finished pulse |

## Verification
The bound checker checks the per-cycle rules on every cycle. The panel switch is only closed inside a sample window, and never during a strobe. Strobes and done pulses last one cycle. A strobe always follows a sample cycle and is followed by a cycle without sampling. The channel select holds steady while sampling, and no window runs longer than sixteen cycles. The phase outputs are mutually exclusive, and the wake-up phase runs only while powered. The bench scenarios alone can show the cycle counts that depend on configuration: the exact wake-up length and when it is skipped, the sample length chosen by each channel's type, the visiting order over sparse masks, the capture of settings at trigger time, the ignored mid-sequence triggers, and the power state left behind by the sleep input.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_IDLE,
    ST_WAKE,
    ST_SAMPLE,
    ST_CONV,
    ST_WAIT,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/adc_seq_cnt.sv
// Loadable down counter; holds at zero.
module adc_seq_cnt #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] val_i,
  output logic             zero_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_pick.sv
// Finds the lowest enabled channel at or above a start index.
module adc_seq_pick #(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask_i,
  input  logic [CHW:0]   from_i,
  output logic           found_o,
  output logic [CHW-1:0] idx_o
);
  logic [NCH-1:0] elig;

  for (genvar g = 0; g < NCH; g++) begin : g_elig
    assign elig[g] = mask_i[g] && (from_i <= (CHW+1)'(g));
  end

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NCH-1; i >= 0; i--) begin
      if (elig[i]) begin
        found_o = 1'b1;
        idx_o   = CHW'(i);
      end
    end
  end
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int STW       = 7,
  parameter int SHW       = 4,
  parameter int STEP_LOG2 = 3,
  localparam int CHW  = $clog2(NCH),
  localparam int CNTW = STW + STEP_LOG2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trig_i,
  input  logic           sleep_mode_i,
  input  logic [STW-1:0] startup_cfg_i,
  input  logic [SHW-1:0] sh_ana_cfg_i,
  input  logic [SHW-1:0] sh_ts_cfg_i,
  input  logic [NCH-1:0] ch_en_i,
  input  logic [NCH-1:0] ch_is_ts_i,
  input  logic           conv_done_i,
  output logic           adc_pwr_o,
  output logic           busy_o,
  output logic           waking_o,
  output logic           sample_o,
  output logic           ts_sw_en_o,
  output logic           conv_start_o,
  output logic [CHW-1:0] ch_sel_o,
  output logic           seq_done_o
);
  seq_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic [NCH-1:0] en_q, ts_q;
  logic [SHW-1:0] sha_q, sht_q;

  // configuration seen by the channel search: live inputs while
  // waiting for a trigger, captured copy once a sequence runs
  logic           use_live;
  logic [NCH-1:0] cfg_en, cfg_ts;
  logic [SHW-1:0] cfg_sha, cfg_sht;
  logic [CHW:0]   from_idx;
  logic           nxt_found;
  logic [CHW-1:0] nxt_idx;
  logic [SHW-1:0] nxt_sh;

  logic            cnt_load, cnt_zero;
  logic [CNTW-1:0] cnt_val;
  logic            accept;

  assign use_live = (state_q == ST_OFF) || (state_q == ST_IDLE);
  assign cfg_en   = use_live ? ch_en_i      : en_q;
  assign cfg_ts   = use_live ? ch_is_ts_i   : ts_q;
  assign cfg_sha  = use_live ? sh_ana_cfg_i : sha_q;
  assign cfg_sht  = use_live ? sh_ts_cfg_i  : sht_q;
  assign from_idx = (state_q == ST_WAIT) ? ({1'b0, ch_q} + 1'b1) : '0;
  assign accept   = use_live && trig_i;

  adc_seq_pick #(.NCH(NCH)) u_pick (
    .mask_i  (cfg_en),
    .from_i  (from_idx),
    .found_o (nxt_found),
    .idx_o   (nxt_idx)
  );

  assign nxt_sh = cfg_ts[nxt_idx] ? cfg_sht : cfg_sha;

  always_comb begin
    state_d  = state_q;
    ch_d     = ch_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_OFF, ST_IDLE: begin
        if (trig_i) begin
          if (!nxt_found) begin
            state_d = ST_DONE;
          end else if (state_q == ST_OFF) begin
            state_d  = ST_WAKE;
            cnt_load = 1'b1;
            cnt_val  = {startup_cfg_i, {STEP_LOG2{1'b1}}};
          end else begin
            state_d  = ST_SAMPLE;
            ch_d     = nxt_idx;
            cnt_load = 1'b1;
            cnt_val  = CNTW'(nxt_sh);
          end
        end
      end
      ST_WAKE: begin
        if (cnt_zero) begin
          state_d  = ST_SAMPLE;
          ch_d     = nxt_idx;
          cnt_load = 1'b1;
          cnt_val  = CNTW'(nxt_sh);
        end
      end
      ST_SAMPLE: begin
        if (cnt_zero) state_d = ST_CONV;
      end
      ST_CONV: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (conv_done_i) begin
          if (nxt_found) begin
            state_d  = ST_SAMPLE;
            ch_d     = nxt_idx;
            cnt_load = 1'b1;
            cnt_val  = CNTW'(nxt_sh);
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        state_d = sleep_mode_i ? ST_OFF : ST_IDLE;
      end
      default: state_d = ST_OFF;
    endcase
  end

  adc_seq_cnt #(.WIDTH(CNTW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .zero_o (cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      ch_q    <= '0;
      en_q    <= '0;
      ts_q    <= '0;
      sha_q   <= '0;
      sht_q   <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      if (accept) begin
        en_q  <= ch_en_i;
        ts_q  <= ch_is_ts_i;
        sha_q <= sh_ana_cfg_i;
        sht_q <= sh_ts_cfg_i;
      end
    end
  end

  assign adc_pwr_o    = (state_q != ST_OFF);
  assign busy_o       = !use_live;
  assign waking_o     = (state_q == ST_WAKE);
  assign sample_o     = (state_q == ST_SAMPLE);
  assign ts_sw_en_o   = (state_q == ST_SAMPLE) && ts_q[ch_q];
  assign conv_start_o = (state_q == ST_CONV);
  assign ch_sel_o     = ch_q;
  assign seq_done_o   = (state_q == ST_DONE);
endmodule

// File: rtl/adc_seq_timer_chk.sv
module adc_seq_timer_chk #(
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           adc_pwr_o,
  input logic           waking_o,
  input logic           sample_o,
  input logic           ts_sw_en_o,
  input logic           conv_start_o,
  input logic [CHW-1:0] ch_sel_o,
  input logic           seq_done_o
);
  logic [4:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (sample_o) run_q <= (run_q == 5'd31) ? run_q : run_q + 1'b1;
    else               run_q <= '0;
  end

  AST_SW_IN_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    ts_sw_en_o |-> sample_o);                                   // R6
  AST_SW_OPEN_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> !ts_sw_en_o);                              // R6
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);                            // R7
  AST_STROBE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_start_o) |-> $past(sample_o));                   // R7
  AST_CH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o || conv_start_o) && $past(sample_o) |-> $stable(ch_sel_o)); // R7
  AST_WAIT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !sample_o);                                // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |=> !seq_done_o);                                // R9
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({waking_o, sample_o, conv_start_o, seq_done_o}));  // R4
  AST_WAKE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    waking_o |-> adc_pwr_o);                                    // R2
  AST_SAMPLE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> run_q < 5'd16);                                // R5
endmodule

bind adc_seq_timer adc_seq_timer_chk #(.CHW(CHW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .adc_pwr_o    (adc_pwr_o),
  .waking_o     (waking_o),
  .sample_o     (sample_o),
  .ts_sw_en_o   (ts_sw_en_o),
  .conv_start_o (conv_start_o),
  .ch_sel_o     (ch_sel_o),
  .seq_done_o   (seq_done_o)
);

// File: tb/test_adc_seq_timer.sv
`timescale 1ns/1ps
module test_adc_seq_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_i = 1'b0, sleep_mode_i = 1'b0, conv_done_i = 1'b0;
  logic [6:0] startup_cfg_i = '0;
  logic [3:0] sh_ana_cfg_i = '0, sh_ts_cfg_i = '0;
  logic [7:0] ch_en_i = '0, ch_is_ts_i = '0;
  logic       adc_pwr_o, busy_o, waking_o, sample_o, ts_sw_en_o, conv_start_o, seq_done_o;
  logic [2:0] ch_sel_o;

  int n_chk = 0, n_fail = 0;
  bit model_asleep = 1'b1;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_seq_timer i_adc_seq_timer (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .sleep_mode_i(sleep_mode_i),
    .startup_cfg_i(startup_cfg_i), .sh_ana_cfg_i(sh_ana_cfg_i), .sh_ts_cfg_i(sh_ts_cfg_i),
    .ch_en_i(ch_en_i), .ch_is_ts_i(ch_is_ts_i), .conv_done_i(conv_done_i),
    .adc_pwr_o(adc_pwr_o), .busy_o(busy_o), .waking_o(waking_o), .sample_o(sample_o),
    .ts_sw_en_o(ts_sw_en_o), .conv_start_o(conv_start_o), .ch_sel_o(ch_sel_o),
    .seq_done_o(seq_done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_ch(input logic [7:0] en, input int from);
    for (int i = from; i < 8; i++) if (en[i]) return i;
    return -1;
  endfunction

  function automatic int exp_wake(input logic [7:0] en, input logic [6:0] su, input bit asleep);
    return (asleep && en != 0) ? (int'(su) + 1) * 8 : 0;
  endfunction

  task automatic run_seq(input logic [7:0] en, input logic [7:0] ty, input logic [6:0] su,
                         input logic [3:0] ma, input logic [3:0] mt, input bit slp,
                         input bit noisy);
    int wake_cnt = 0, samp = 0, tsc = 0, nconv = 0, pending = 0, dones = 0, stray = 0;
    int ew, ech;
    bit first = 1'b1, inwait = 1'b0;
    ew  = exp_wake(en, su, model_asleep);
    ech = next_ch(en, 0);
    ch_en_i = en; ch_is_ts_i = ty; startup_cfg_i = su;
    sh_ana_cfg_i = ma; sh_ts_cfg_i = mt; sleep_mode_i = slp;
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    if (noisy) begin  // R10: settings change after acceptance
      ch_en_i = 8'($urandom); ch_is_ts_i = 8'($urandom);
      sh_ana_cfg_i = 4'($urandom); sh_ts_cfg_i = 4'($urandom);
    end
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (first) begin
        if (ew != 0)       chk(waking_o == 1'b1, "R2 wake starts", waking_o, 1);
        else if (en == 0)  chk(seq_done_o == 1'b1, "R11 empty mask done", seq_done_o, 1);
        else               chk(sample_o == 1'b1, "R3 immediate sample", sample_o, 1);
        first = 1'b0;
      end
      if (conv_done_i) begin
        conv_done_i = 1'b0;
        inwait = 1'b0;
        chk(sample_o || seq_done_o, "R4 resume next cycle", sample_o, 1);
      end
      if (inwait && (sample_o || conv_start_o)) stray++;
      if (waking_o) wake_cnt++;
      if (sample_o) begin
        samp++;
        if (ts_sw_en_o) tsc++;
      end
      if (conv_start_o) begin
        chk(int'(ch_sel_o) == ech, "R4 channel order", ch_sel_o, ech);
        if (ech >= 0) begin
          chk(samp == int'(ty[ech] ? mt : ma) + 1, "R5 sample length", samp,
              int'(ty[ech] ? mt : ma) + 1);
          chk(tsc == (ty[ech] ? int'(mt) + 1 : 0), "R6 switch cycles", tsc,
              ty[ech] ? int'(mt) + 1 : 0);
          ech = next_ch(en, ech + 1);
        end
        chk(ts_sw_en_o == 1'b0, "R6 switch open at strobe", ts_sw_en_o, 0);
        nconv++; samp = 0; tsc = 0; inwait = 1'b1;
      end
      if (pending > 0) begin
        pending--;
        if (pending == 0) conv_done_i = 1'b1;
      end
      if (conv_start_o) pending = 1 + int'($urandom % 4);
      if (seq_done_o) dones++;
      trig_i = noisy && ($urandom % 4 == 0);
      if (seq_done_o) break;
      @(negedge clk);
    end
    @(negedge clk);
    trig_i = 1'b0;
    chk(dones == 1, "R9 one done pulse", dones, 1);
    chk(seq_done_o == 1'b0, "R9 done is a pulse", seq_done_o, 0);
    chk(busy_o == 1'b0, "R9 idle after done", busy_o, 0);
    chk(adc_pwr_o == !slp, "R9 power after sequence", adc_pwr_o, !slp);
    chk(wake_cnt == ew, ew != 0 ? "R2 wake length" : "R3 no wake", wake_cnt, ew);
    chk(nconv == $countones(en), "R4 conversion count", nconv, $countones(en));
    chk(stray == 0, "R8 idle while converting", stray, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!busy_o && !sample_o && !waking_o, "R10 ignored trigger", busy_o, 0);
    end
    model_asleep = slp;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk({adc_pwr_o, busy_o, waking_o, sample_o, ts_sw_en_o, conv_start_o, seq_done_o} == 0,
        "R1 reset outputs", adc_pwr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({adc_pwr_o, busy_o, waking_o, sample_o, ts_sw_en_o, conv_start_o, seq_done_o} == 0,
        "R1 after release", busy_o, 0);
    // directed corners
    run_seq(8'h00, 8'h00, 7'd3,   4'd2,  4'd5,  1'b1, 1'b0); // R11 empty, asleep
    run_seq(8'h81, 8'h01, 7'd0,   4'd0,  4'd15, 1'b0, 1'b0); // R2 minimum wake
    run_seq(8'hFF, 8'hAA, 7'd5,   4'd15, 4'd0,  1'b0, 1'b1); // R3 R10 powered
    run_seq(8'h80, 8'h80, 7'd9,   4'd3,  4'd7,  1'b1, 1'b0); // R4 top channel only
    run_seq(8'h24, 8'h00, 7'd127, 4'd1,  4'd2,  1'b1, 1'b1); // R2 maximum wake
    run_seq(8'h00, 8'h00, 7'd7,   4'd1,  4'd1,  1'b0, 1'b0); // R11 empty from asleep
    for (int n = 0; n < 40; n++) begin
      run_seq(8'($urandom), 8'($urandom), 7'($urandom % 16), 4'($urandom), 4'($urandom),
              1'($urandom), 1'($urandom));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule